// File: doc/BRIEF.md
# Remappable Memory-Map Address Decoder

This block sits between a processor's address bus and the on-chip memories and register blocks. Each cycle it takes one request: a valid strobe, a read/write flag, a 32-bit byte address and write data. It works out which region the address falls in. It then drives a one-hot region select, a chip select for each of the two memory arrays, and the byte offset into the selected target. It also reports how many bus cycles the access takes, and it raises an error flag for addresses that belong to no region.

The lowest window of the map, starting at address zero, is an alias. After reset it maps the Flash array, so a boot fetch from address zero reads Flash. A one-bit remap register sits inside the register space. Writing a zero to it makes the zero window alias SRAM instead, and writing a one moves the window back to Flash. The window is always exactly as large as the array it currently aliases. The top 2 kB of Flash are kept for system code, and the decoder refuses user writes to that area, whether the write comes through the Flash range or through the alias.

Top module: `addrMapDecoder`

## Requirements
- R1: After reset the remap bit reads 1 and an access at 0x00000000 raises regionSel bit 0 together with flashCs, with memOffset equal to the address.
- R2: A valid write to the remap register takes the new bit from reqWdata[0]. From the next cycle on, 0 makes the zero window raise sramCs and 1 makes it raise flashCs.
- R3: The zero window spans 0x00000000 up to the size of the aliased array: 128 kB for Flash, 32 kB for SRAM. Addresses in the low region past that size are reserved.
- R4: Addresses 0x00040000 to 0x00047FFF raise regionSel bit 1 and sramCs, with memOffset equal to the address minus 0x00040000.
- R5: Addresses 0x00080000 to 0x0009FFFF raise regionSel bit 2 and flashCs, with memOffset equal to the address minus 0x00080000. Reads of the top 2 kB are allowed.
- R6: A write that would reach Flash offsets 0x1F800 to 0x1FFFF, either directly or through the zero window, is refused. It raises accessErr and selects nothing.
- R7: Addresses 0xFFFF0000 and above raise regionSel bit 3, with memOffset equal to the address minus 0xFFFF0000. A read of the word at offset 0x220 returns the remap bit in rdata[0], with all other bits zero.
- R8: waitCycles is 1 for SRAM, Flash, the zero window and the fast register block at offsets 0xF000 to 0xF3FF. It is 2 for the rest of the register space, and 0 when nothing is selected.
- R9: Any other address raises accessErr. It leaves regionSel, sramCs, flashCs, memOffset, waitCycles and rdata all zero.
- R10: When reqValid is low, all outputs are zero and a write to the remap register has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqAddr | input | 32 | Byte address |
| reqWdata | input | 32 | Write data (bit 0 feeds the remap register) |
| regionSel | output | 4 | One-hot region: bit0 zero window, bit1 SRAM, bit2 Flash, bit3 registers |
| sramCs | output | 1 | SRAM array chip select |
| flashCs | output | 1 | Flash array chip select |
| memOffset | output | 17 | Byte offset into the selected target |
| waitCycles | output | 2 | Bus cycles for this access (0, 1 or 2) |
| accessErr | output | 1 | Reserved or refused access |
| rdata | output | 32 | Remap register readback, zero otherwise |

## Verification
Every decode result is combinational, so selects, offset, cycle count, error and readback belong to the same cycle as the request that causes them. The bench drives each request just after a falling edge and compares the outputs one nanosecond later, well before the next rising edge. A write to the remap register only changes the alias at the rising edge that accepts it. The checks that depend on the new setting therefore use requests issued in a later cycle, with no extra idle cycle between them, which also shows that the change takes effect after exactly one edge.

// File: rtl/addr_map_pkg.sv
package addr_map_pkg;

  // region select bit positions
  localparam int SEL_LOW   = 0;
  localparam int SEL_SRAM  = 1;
  localparam int SEL_FLASH = 2;
  localparam int SEL_REG   = 3;
  localparam int SEL_COUNT = 4;

  // access cycle counts
  localparam logic [1:0] CYC_NONE = 2'd0;
  localparam logic [1:0] CYC_FAST = 2'd1;
  localparam logic [1:0] CYC_SLOW = 2'd2;

  // strobes from the address compare logic to the datapath
  typedef struct packed {
    logic hitLow;
    logic hitSram;
    logic hitFlash;
    logic hitReg;
    logic hitFast;
    logic remapWr;
    logic remapRd;
    logic reserved;
  } decStrobe_t;

endpackage

// File: rtl/addrDecodeCtrl.sv
module addrDecodeCtrl
  import addr_map_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] SRAM_BASE   = 'h0004_0000,
  parameter int unsigned       SRAM_BYTES  = 32768,
  parameter logic [ADDR_W-1:0] FLASH_BASE  = 'h0008_0000,
  parameter int unsigned       FLASH_BYTES = 131072,
  parameter int unsigned       SYS_BYTES   = 2048,
  parameter logic [ADDR_W-1:0] REG_BASE    = 'hFFFF_0000,
  parameter int unsigned       REG_OFS_W   = 16,
  parameter int unsigned       REMAP_OFS   = 'h220,
  parameter int unsigned       FAST_OFS    = 'hF000,
  parameter int unsigned       FAST_BYTES  = 'h400
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              aliasSram,
  output decStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] SRAM_END   = SRAM_BASE + ADDR_W'(SRAM_BYTES);
  localparam logic [ADDR_W-1:0] FLASH_END  = FLASH_BASE + ADDR_W'(FLASH_BYTES);
  localparam logic [ADDR_W-1:0] SYS_OFS    = ADDR_W'(FLASH_BYTES - SYS_BYTES);
  localparam logic [ADDR_W-1:0] SYS_ABS    = FLASH_BASE + SYS_OFS;
  localparam logic [ADDR_W-1:0] LOW_SRAM   = ADDR_W'(SRAM_BYTES);
  localparam logic [ADDR_W-1:0] LOW_FLASH  = ADDR_W'(FLASH_BYTES);
  localparam logic [REG_OFS_W-1:0] REMAP_W = REG_OFS_W'(REMAP_OFS);
  localparam logic [REG_OFS_W-1:0] FAST_LO = REG_OFS_W'(FAST_OFS);
  localparam logic [REG_OFS_W-1:0] FAST_HI = REG_OFS_W'(FAST_OFS + FAST_BYTES);

  logic [ADDR_W-1:0]    lowLimit;
  logic                 inLow, inSram, inFlash, inReg;
  logic                 sysWrite;
  logic                 accepted;
  logic [REG_OFS_W-1:0] regOfs;
  logic                 onRemapWord, inFastBlk;

  always_comb begin
    lowLimit = aliasSram ? LOW_SRAM : LOW_FLASH;
    inLow    = reqAddr < lowLimit;
    inSram   = (reqAddr >= SRAM_BASE) && (reqAddr < SRAM_END);
    inFlash  = (reqAddr >= FLASH_BASE) && (reqAddr < FLASH_END);
    inReg    = reqAddr >= REG_BASE;
  end

  // system area of Flash, reached directly or through the Flash alias
  always_comb begin
    sysWrite = 1'b0;
    if (reqWrite) begin
      if (inFlash && (reqAddr >= SYS_ABS)) sysWrite = 1'b1;
      if (inLow && !aliasSram && (reqAddr >= SYS_OFS)) sysWrite = 1'b1;
    end
  end

  // register space is aligned, so the low bits are the offset
  always_comb begin
    regOfs      = reqAddr[REG_OFS_W-1:0];
    onRemapWord = regOfs[REG_OFS_W-1:2] == REMAP_W[REG_OFS_W-1:2];
    inFastBlk   = (regOfs >= FAST_LO) && (regOfs < FAST_HI);
  end

  assign accepted = reqValid && !sysWrite;

  always_comb begin
    strobe          = '0;
    strobe.hitLow   = accepted && inLow;
    strobe.hitSram  = accepted && inSram;
    strobe.hitFlash = accepted && inFlash;
    strobe.hitReg   = accepted && inReg;
    strobe.hitFast  = accepted && inReg && inFastBlk;
    strobe.remapWr  = accepted && inReg && onRemapWord && reqWrite;
    strobe.remapRd  = accepted && inReg && onRemapWord && !reqWrite;
    strobe.reserved = reqValid && (sysWrite || !(inLow || inSram || inFlash || inReg));
  end

endmodule

// File: rtl/addrMapDatapath.sv
module addrMapDatapath
  import addr_map_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter int                DATA_W      = 32,
  parameter int                OFS_W       = 17,
  parameter int unsigned       REG_OFS_W   = 16,
  parameter logic [ADDR_W-1:0] SRAM_BASE   = 'h0004_0000,
  parameter logic [ADDR_W-1:0] FLASH_BASE  = 'h0008_0000,
  parameter int unsigned       FLASH_BYTES = 131072,
  parameter int unsigned       SYS_BYTES   = 2048
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic                 wrBit,
  input  decStrobe_t           strobe,
  output logic                 aliasSram,
  output logic [SEL_COUNT-1:0] regionSel,
  output logic                 sramCs,
  output logic                 flashCs,
  output logic [OFS_W-1:0]     memOffset,
  output logic [1:0]           waitCycles,
  output logic                 accessErr,
  output logic [DATA_W-1:0]    rdata
);

  localparam logic [OFS_W-1:0] SRAM_B  = SRAM_BASE[OFS_W-1:0];
  localparam logic [OFS_W-1:0] FLASH_B = FLASH_BASE[OFS_W-1:0];
  localparam logic [OFS_W-1:0] SYS_OFS = OFS_W'(FLASH_BYTES - SYS_BYTES);

  logic remapQ;

  // remap register: 1 = zero window aliases Flash
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              remapQ <= 1'b1;
    else if (strobe.remapWr) remapQ <= wrBit;
  end

  assign aliasSram = !remapQ;

  always_comb begin
    regionSel            = '0;
    regionSel[SEL_LOW]   = strobe.hitLow;
    regionSel[SEL_SRAM]  = strobe.hitSram;
    regionSel[SEL_FLASH] = strobe.hitFlash;
    regionSel[SEL_REG]   = strobe.hitReg;
    sramCs  = strobe.hitSram  || (strobe.hitLow && aliasSram);
    flashCs = strobe.hitFlash || (strobe.hitLow && !aliasSram);
  end

  always_comb begin
    memOffset = '0;
    if (strobe.hitLow)        memOffset = reqAddr[OFS_W-1:0];
    else if (strobe.hitSram)  memOffset = reqAddr[OFS_W-1:0] - SRAM_B;
    else if (strobe.hitFlash) memOffset = reqAddr[OFS_W-1:0] - FLASH_B;
    else if (strobe.hitReg)   memOffset = OFS_W'(reqAddr[REG_OFS_W-1:0]);
  end

  always_comb begin
    waitCycles = CYC_NONE;
    if (strobe.hitReg && !strobe.hitFast) waitCycles = CYC_SLOW;
    else if (|regionSel)                  waitCycles = CYC_FAST;
  end

  always_comb begin
    rdata     = '0;
    rdata[0]  = strobe.remapRd && remapQ;
    accessErr = strobe.reserved;
  end

  // R1
  remap_rst_chk: assert property (@(posedge clk) !rstN |=> remapQ);

  // R2
  remap_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.remapWr |=> (remapQ == $past(wrBit)));

  // R9
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(regionSel));

  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    accessErr |-> (regionSel == '0 && !sramCs && !flashCs && rdata == '0));

  // R6
  sys_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flashCs && reqWrite) |-> (memOffset < SYS_OFS));

  // R8
  wait_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sramCs && !flashCs && regionSel == '0) |-> (waitCycles == CYC_NONE));

endmodule

// File: rtl/addrMapDecoder.sv
module addrMapDecoder
  import addr_map_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter int                DATA_W      = 32,
  parameter logic [ADDR_W-1:0] SRAM_BASE   = 'h0004_0000,
  parameter int unsigned       SRAM_BYTES  = 32768,
  parameter logic [ADDR_W-1:0] FLASH_BASE  = 'h0008_0000,
  parameter int unsigned       FLASH_BYTES = 131072,
  parameter int unsigned       SYS_BYTES   = 2048,
  parameter logic [ADDR_W-1:0] REG_BASE    = 'hFFFF_0000,
  parameter int unsigned       REG_BYTES   = 65536,
  parameter int unsigned       REMAP_OFS   = 'h220,
  parameter int unsigned       FAST_OFS    = 'hF000,
  parameter int unsigned       FAST_BYTES  = 'h400,
  localparam int unsigned      ARR_BYTES   = (FLASH_BYTES > SRAM_BYTES) ? FLASH_BYTES : SRAM_BYTES,
  localparam int unsigned      REG_OFS_W   = $clog2(REG_BYTES),
  localparam int unsigned      ARR_OFS_W   = $clog2(ARR_BYTES),
  localparam int               OFS_W       = (ARR_OFS_W > REG_OFS_W) ? ARR_OFS_W : REG_OFS_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  output logic [SEL_COUNT-1:0] regionSel,
  output logic                 sramCs,
  output logic                 flashCs,
  output logic [OFS_W-1:0]     memOffset,
  output logic [1:0]           waitCycles,
  output logic                 accessErr,
  output logic [DATA_W-1:0]    rdata
);

  decStrobe_t strobe;
  logic       aliasSram;
  logic       unusedWdata;

  assign unusedWdata = ^reqWdata[DATA_W-1:1];

  addrDecodeCtrl #(
    .ADDR_W(ADDR_W), .SRAM_BASE(SRAM_BASE), .SRAM_BYTES(SRAM_BYTES),
    .FLASH_BASE(FLASH_BASE), .FLASH_BYTES(FLASH_BYTES), .SYS_BYTES(SYS_BYTES),
    .REG_BASE(REG_BASE), .REG_OFS_W(REG_OFS_W), .REMAP_OFS(REMAP_OFS),
    .FAST_OFS(FAST_OFS), .FAST_BYTES(FAST_BYTES)
  ) uCtrl (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .aliasSram(aliasSram),
    .strobe   (strobe)
  );

  addrMapDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W), .REG_OFS_W(REG_OFS_W),
    .SRAM_BASE(SRAM_BASE), .FLASH_BASE(FLASH_BASE),
    .FLASH_BYTES(FLASH_BYTES), .SYS_BYTES(SYS_BYTES)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .reqWrite  (reqWrite),
    .reqAddr   (reqAddr),
    .wrBit     (reqWdata[0]),
    .strobe    (strobe),
    .aliasSram (aliasSram),
    .regionSel (regionSel),
    .sramCs    (sramCs),
    .flashCs   (flashCs),
    .memOffset (memOffset),
    .waitCycles(waitCycles),
    .accessErr (accessErr),
    .rdata     (rdata)
  );

endmodule

// File: tb/tb_addrMapDecoder.sv
`timescale 1ns/1ps
module tb_addrMapDecoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [3:0]  regionSel;
  logic        sramCs, flashCs;
  logic [16:0] memOffset;
  logic [1:0]  waitCycles;
  logic        accessErr;
  logic [31:0] rdata;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  addrMapDecoder dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .regionSel(regionSel),
    .sramCs(sramCs), .flashCs(flashCs), .memOffset(memOffset),
    .waitCycles(waitCycles), .accessErr(accessErr), .rdata(rdata)
  );

  typedef struct {
    string       tag;
    logic [3:0]  sel;
    logic        sCs;
    logic        fCs;
    logic [16:0] ofs;
    logic [1:0]  cyc;
    logic        err;
    logic [31:0] rd;
  } expect_t;

  expect_t expQ[$];

  task automatic drive(input string tag, input logic v, input logic w,
                       input logic [31:0] a, input logic [31:0] d,
                       input logic [3:0] sel, input logic sCs, input logic fCs,
                       input logic [16:0] ofs, input logic [1:0] cyc,
                       input logic err, input logic [31:0] rd);
    expect_t e;
    @(negedge clk);
    reqValid = v; reqWrite = w; reqAddr = a; reqWdata = d;
    e.tag = tag; e.sel = sel; e.sCs = sCs; e.fCs = fCs;
    e.ofs = ofs; e.cyc = cyc; e.err = err; e.rd = rd;
    expQ.push_back(e);
  endtask

  // shorthand for a refused or reserved access
  task automatic driveErr(input string tag, input logic w, input logic [31:0] a);
    drive(tag, 1'b1, w, a, 32'h0, 4'b0000, 1'b0, 1'b0, 17'h0, 2'd0, 1'b1, 32'h0);
  endtask

  // monitor: compares one nanosecond after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (expQ.size() > 0) begin
        expect_t e;
        e = expQ.pop_front();
        total++;
        if (regionSel !== e.sel || sramCs !== e.sCs || flashCs !== e.fCs ||
            memOffset !== e.ofs || waitCycles !== e.cyc || accessErr !== e.err ||
            rdata !== e.rd) begin
          bad++;
          $display("FAIL %s: got sel=%b s=%b f=%b ofs=%h cyc=%0d err=%b rd=%h exp sel=%b s=%b f=%b ofs=%h cyc=%0d err=%b rd=%h",
                   e.tag, regionSel, sramCs, flashCs, memOffset, waitCycles, accessErr, rdata,
                   e.sel, e.sCs, e.fCs, e.ofs, e.cyc, e.err, e.rd);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R10 idle outputs
    drive("R10 idle", 0, 0, 32'h0, 0, 4'b0000, 0, 0, 17'h0, 2'd0, 0, 32'h0);
    // R1 boot alias to Flash
    drive("R1 zero", 1, 0, 32'h0000_0000, 0, 4'b0001, 0, 1, 17'h0, 2'd1, 0, 32'h0);
    drive("R1 low flash", 1, 0, 32'h0000_0010, 0, 4'b0001, 0, 1, 17'h10, 2'd1, 0, 32'h0);
    // R7 readback of reset value
    drive("R7 remap rd", 1, 0, 32'hFFFF_0220, 0, 4'b1000, 0, 0, 17'h220, 2'd2, 0, 32'h1);
    // R3 window size with Flash alias
    drive("R3 flash top", 1, 0, 32'h0001_FFFC, 0, 4'b0001, 0, 1, 17'h1FFFC, 2'd1, 0, 32'h0);
    driveErr("R3 past flash window", 0, 32'h0002_0000);
    // R6 alias write into system area
    driveErr("R6 alias sys wr", 1, 32'h0001_F800);
    // R4 SRAM
    drive("R4 sram rd", 1, 0, 32'h0004_0004, 0, 4'b0010, 1, 0, 17'h4, 2'd1, 0, 32'h0);
    drive("R4 sram wr end", 1, 1, 32'h0004_7FFC, 0, 4'b0010, 1, 0, 17'h7FFC, 2'd1, 0, 32'h0);
    // R5 Flash, system area readable
    drive("R5 flash sys rd", 1, 0, 32'h0009_F800, 0, 4'b0100, 0, 1, 17'h1F800, 2'd1, 0, 32'h0);
    drive("R5 flash wr", 1, 1, 32'h0009_F7FC, 0, 4'b0100, 0, 1, 17'h1F7FC, 2'd1, 0, 32'h0);
    // R6 direct write to system area
    driveErr("R6 flash sys wr", 1, 32'h0009_F800);
    driveErr("R6 flash sys wr top", 1, 32'h0009_FFFC);
    // R8 cycle counts in register space
    drive("R8 fast blk", 1, 0, 32'hFFFF_F010, 0, 4'b1000, 0, 0, 17'hF010, 2'd1, 0, 32'h0);
    drive("R8 fast blk end", 1, 0, 32'hFFFF_F3FC, 0, 4'b1000, 0, 0, 17'hF3FC, 2'd1, 0, 32'h0);
    drive("R8 slow reg", 1, 0, 32'hFFFF_F400, 0, 4'b1000, 0, 0, 17'hF400, 2'd2, 0, 32'h0);
    drive("R7 reg top", 1, 1, 32'hFFFF_FFFC, 0, 4'b1000, 0, 0, 17'hFFFC, 2'd2, 0, 32'h0);
    // R9 reserved holes
    driveErr("R9 hole sram", 0, 32'h0004_8000);
    driveErr("R9 hole flash", 0, 32'h000A_0000);
    driveErr("R9 below regs", 0, 32'hFFFE_FFFC);
    driveErr("R9 mid hole", 1, 32'h1234_5678);
    // R10 invalid write to remap has no effect
    drive("R10 invalid wr", 0, 1, 32'hFFFF_0220, 32'h0, 4'b0000, 0, 0, 17'h0, 2'd0, 0, 32'h0);
    drive("R10 remap kept", 1, 0, 32'hFFFF_0220, 0, 4'b1000, 0, 0, 17'h220, 2'd2, 0, 32'h1);
    // R2 switch alias to SRAM
    drive("R2 remap wr0", 1, 1, 32'hFFFF_0220, 32'hFFFF_FFFE, 4'b1000, 0, 0, 17'h220, 2'd2, 0, 32'h0);
    drive("R2 low sram", 1, 0, 32'h0000_0010, 0, 4'b0001, 1, 0, 17'h10, 2'd1, 0, 32'h0);
    drive("R7 remap rd0", 1, 0, 32'hFFFF_0220, 0, 4'b1000, 0, 0, 17'h220, 2'd2, 0, 32'h0);
    // R3 window size with SRAM alias
    drive("R3 sram top", 1, 1, 32'h0000_7FFC, 0, 4'b0001, 1, 0, 17'h7FFC, 2'd1, 0, 32'h0);
    driveErr("R3 past sram window", 0, 32'h0000_8000);
    // R2 back to Flash
    drive("R2 remap wr1", 1, 1, 32'hFFFF_0220, 32'h0000_0001, 4'b1000, 0, 0, 17'h220, 2'd2, 0, 32'h0);
    drive("R2 low flash again", 1, 0, 32'h0000_8000, 0, 4'b0001, 0, 1, 17'h8000, 2'd1, 0, 32'h0);

    drive("R10 idle end", 0, 0, 32'h0, 0, 4'b0000, 0, 0, 17'h0, 2'd0, 0, 32'h0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule